// File: doc/BRIEF.md
# Serial Word-Load Programming Sequencer

This block carries the digital control flow of the programming mode of a serial configuration memory. While the programming-mode flag is high, an external programmer writes the array one 32-bit word at a time. Pulling chip enable low empties the data latch. With chip enable high, 32 serial-clock strobes then shift in one data bit each, first bit to the most significant position. Once the 32nd bit is in, the block raises a write strobe for a fixed number of cycles. The write strobe carries the current word address and the latch contents to the array. One more serial-clock strobe after the strobe ends moves the word counter to the next word.

Words are written back to back. Verification reads are left to a later pass and are not part of this block. Two conditions raise sticky flags:
- a serial clock that arrives while the write strobe is active;
- a load attempt after the last word has been written.

The block also drives the cascade output. In programming mode it shows the configured reset polarity; outside programming mode its enable is released. A registered drive enable for the data pin stays low while chip enable is low and while a word is being shifted in.

Top module: `serial_word_programmer`

## Requirements
- R1: After reset, and before programming mode is entered, wr_en, err_flag, ovf_flag, data_oe and cas_oe are 0, and wr_addr and wr_data are 0.
- R2: With prog_mode high, ce_n low at a clock edge clears wr_data to 0 and restarts the bit count, so that a partly loaded word is discarded.
- R3: With ce_n high after a clear, each cycle with sclk_en high shifts sdin into bit 0 of the latch. Earlier bits move toward bit DATA_W-1, so the first bit received ends at bit 31. wr_data always shows the latch.
- R4: The edge that takes in the 32nd bit makes wr_en high from the next cycle. wr_en stays high for exactly PULSE_CYC cycles, and wr_addr holds the current word throughout.
- R5: An sclk_en strobe while wr_en is high shifts nothing: wr_data and wr_addr do not change. The strobe sets err_flag, which stays set until programming mode ends.
- R6: The first sclk_en strobe after the write strobe ends adds one to wr_addr. At word WORDS-1 the address saturates and stays at WORDS-1.
- R7: Once word WORDS-1 has been written and its increment strobe received, a later load attempt (sclk_en after a clear) shifts nothing and produces no wr_en pulse. It sets ovf_flag.
- R8: While prog_mode is high, cas_oe is 1 and cas_out equals rst_pol. While prog_mode is low, cas_oe and cas_out are 0.
- R9: data_oe is 1 one cycle after an edge at which prog_mode and ce_n were high and the block was not loading a word. It is 0 while ce_n is low and throughout a word load.
- R10: Dropping prog_mode returns wr_addr, the latch, the bit count, err_flag and ovf_flag to 0 at the next edge. The next word is then written at address 0.
- R11: sclk_en strobes after an increment, before chip enable has been pulled low again, change neither wr_data nor wr_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_mode | input | 1 | Programming-mode flag |
| rst_pol | input | 1 | Configured reset polarity, shown on cascade output |
| ce_n | input | 1 | Chip enable, active low; low clears the latch |
| sclk_en | input | 1 | One-cycle serial clock strobe |
| sdin | input | 1 | Serial data bit |
| wr_en | output | 1 | Write strobe to the array |
| wr_addr | output | AW | Word address being written |
| wr_data | output | DATA_W | Latch contents to be written |
| data_oe | output | 1 | Data-pin drive enable |
| cas_out | output | 1 | Cascade output value |
| cas_oe | output | 1 | Cascade output enable |
| err_flag | output | 1 | Serial clock seen during the write strobe |
| ovf_flag | output | 1 | Load attempted after the last word |

## Verification
Every result except the cascade pins is registered. wr_data, wr_addr, the flags and data_oe are therefore due one cycle after the edge that takes in the stimulus, and wr_en rises one cycle after the 32nd bit. The bench drives inputs on the falling edge and samples at the next falling edge, so each check sees the state exactly one register stage after its stimulus. The strobe width is measured by counting falling-edge samples with wr_en high until it drops, and the result is compared with PULSE_CYC. The cascade pins are combinational and are checked in the same half cycle as the change to rst_pol or prog_mode.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PULSE = 2'd2,
        ST_INCR  = 2'd3
    } swp_state_e;
endpackage

// File: rtl/swp_pulse_timer.sv
module swp_pulse_timer #(
    parameter int PULSE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int PCW = $clog2(PULSE_CYC + 1);

    logic [PCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (start)
            cnt_d = PCW'(PULSE_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == PCW'(1));

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |-> !start)
        else $error("timer restarted while running");
endmodule

// File: rtl/swp_word_ctr.sv
module swp_word_ctr #(
    parameter int WORDS = 16,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr)
            addr_d = '0;
        else if (inc && addr_q != AW'(WORDS - 1))
            addr_d = addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == AW'(WORDS - 1));

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0))
        else $error("address moved by other than one");
    a_r6_bound: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= AW'(WORDS - 1))
        else $error("address past last word");
endmodule

// File: rtl/serial_word_programmer.sv
module serial_word_programmer #(
    parameter int DATA_W    = 32,
    parameter int WORDS     = 16,
    parameter int PULSE_CYC = 8,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              rst_pol,
    input  logic              ce_n,
    input  logic              sclk_en,
    input  logic              sdin,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              data_oe,
    output logic              cas_out,
    output logic              cas_oe,
    output logic              err_flag,
    output logic              ovf_flag
);
    import swp_pkg::*;

    localparam int BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);
    localparam int HCW = $clog2(PULSE_CYC + 2) + 1;

    typedef struct packed {
        swp_state_e       st;
        logic [DATA_W-1:0] latch;
        logic [BCW-1:0]   bits;
        logic             err;
        logic             ovf;
        logic             full;
        logic             doe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tmr_start, tmr_active, tmr_last;
    logic ctr_inc, ctr_last;
    logic [AW-1:0] ctr_addr;

    swp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!prog_mode),
        .start  (tmr_start),
        .active (tmr_active),
        .last   (tmr_last)
    );

    swp_word_ctr #(.WORDS(WORDS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!prog_mode),
        .inc     (ctr_inc),
        .addr    (ctr_addr),
        .at_last (ctr_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        ctr_inc   = 1'b0;
        ctl_d.doe = prog_mode && ce_n && (ctl_q.st != ST_LOAD);
        if (!prog_mode) begin
            ctl_d    = '0;
            ctl_d.st = ST_IDLE;
        end else begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (!ce_n) begin
                        ctl_d.latch = '0;
                        ctl_d.bits  = '0;
                        ctl_d.st    = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (!ce_n) begin
                        ctl_d.latch = '0;
                        ctl_d.bits  = '0;
                    end else if (sclk_en) begin
                        if (ctl_q.full) begin
                            ctl_d.ovf = 1'b1;
                        end else begin
                            ctl_d.latch = {ctl_q.latch[DATA_W-2:0], sdin};
                            if (ctl_q.bits == LAST_BIT) begin
                                ctl_d.bits = '0;
                                ctl_d.st   = ST_PULSE;
                                tmr_start  = 1'b1;
                            end else begin
                                ctl_d.bits = ctl_q.bits + 1'b1;
                            end
                        end
                    end
                end
                ST_PULSE: begin
                    if (sclk_en)  ctl_d.err = 1'b1;
                    if (tmr_last) ctl_d.st  = ST_INCR;
                end
                ST_INCR: begin
                    if (sclk_en) begin
                        if (ctr_last) ctl_d.full = 1'b1;
                        else          ctr_inc    = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_en    = tmr_active;
    assign wr_addr  = ctr_addr;
    assign wr_data  = ctl_q.latch;
    assign data_oe  = ctl_q.doe;
    assign err_flag = ctl_q.err;
    assign ovf_flag = ctl_q.ovf;
    assign cas_oe   = prog_mode;
    assign cas_out  = prog_mode & rst_pol;

    // strobe width monitor
    logic [HCW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_cnt_q <= '0;
        else if (wr_en) hi_cnt_q <= hi_cnt_q + 1'b1;
        else            hi_cnt_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r4_width_max: assert (hi_cnt_q <= HCW'(PULSE_CYC))
                else $error("write strobe too long");
            if (!wr_en && hi_cnt_q != '0 && prog_mode)
                a_r4_width_exact: assert (hi_cnt_q == HCW'(PULSE_CYC))
                    else $error("write strobe width wrong");
        end
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> ($stable(wr_data) && $stable(wr_addr)))
        else $error("latch or address moved during strobe");
    a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |=> (!wr_en && !err_flag && !ovf_flag && wr_addr == '0))
        else $error("state kept after leaving mode");
    a_r9_doe: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ($past(ce_n) && $past(prog_mode)))
        else $error("data pin driven with chip enable low");
endmodule

// File: tb/sim_serial_word_programmer.sv
module sim_serial_word_programmer;
    localparam int DW = 32;
    localparam int NW = 4;
    localparam int PC = 5;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_mode = 1'b0, rst_pol = 1'b0, ce_n = 1'b1, sclk_en = 1'b0, sdin = 1'b0;
    logic wr_en, data_oe, cas_out, cas_oe, err_flag, ovf_flag;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_word_programmer #(.DATA_W(DW), .WORDS(NW), .PULSE_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .rst_pol(rst_pol),
        .ce_n(ce_n), .sclk_en(sclk_en), .sdin(sdin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .data_oe(data_oe),
        .cas_out(cas_out), .cas_oe(cas_oe), .err_flag(err_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int w, input int seed);
        return (32'hA5C3_96E1 ^ (32'(w + 1) * 32'h0101_1357)) + 32'(seed) * 32'h2468_ACE1;
    endfunction

    // clear, shift 32 bits, measure strobe, optional strobe during pulse
    task automatic write_word(input int w, input logic [DW-1:0] v, input bit inject, input int exp_addr);
        int hi;
        ce_n = 1'b0; step();
        chk(wr_data == '0, "R2 clear on ce_n low", 64'(wr_data), 0);
        chk(data_oe == 1'b0, "R9 no drive with ce_n low", 64'(data_oe), 0);
        ce_n = 1'b1; step();
        for (int i = 0; i < DW; i++) begin
            sdin = v[DW-1-i]; sclk_en = 1'b1; step();
            if (i == DW - 2) chk(wr_en == 1'b0, "R4 no strobe before 32nd bit", 64'(wr_en), 0);
            if (i == 10) chk(data_oe == 1'b0, "R9 no drive during load", 64'(data_oe), 0);
        end
        sclk_en = 1'b0;
        chk(wr_data == v, "R3 shifted word", 64'(wr_data), 64'(v));
        chk(wr_addr == AW'(exp_addr), "R4 address during strobe", 64'(wr_addr), 64'(exp_addr));
        hi = 0;
        while (wr_en && hi < 100) begin
            hi++;
            if (inject && hi == 2) begin
                sclk_en = 1'b1; sdin = ~v[0]; step(); sclk_en = 1'b0;
                chk(wr_data == v, "R5 strobe ignored, data held", 64'(wr_data), 64'(v));
                chk(err_flag == 1'b1, "R5 error flag set", 64'(err_flag), 1);
            end else begin
                step();
            end
        end
        chk(hi == PC, "R4 strobe width", 64'(hi), 64'(PC));
        sclk_en = 1'b1; step(); sclk_en = 1'b0;
        chk(wr_addr == AW'((w + 1 < NW) ? w + 1 : NW - 1), "R6 increment or saturate",
            64'(wr_addr), 64'((w + 1 < NW) ? w + 1 : NW - 1));
        step();
        chk(data_oe == 1'b1, "R9 drive when idle", 64'(data_oe), 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1; step();
        chk({wr_en, err_flag, ovf_flag, data_oe, cas_oe} == 5'b0, "R1 reset outputs", 64'({wr_en, err_flag, ovf_flag, data_oe, cas_oe}), 0);
        chk(wr_addr == '0 && wr_data == '0, "R1 reset address/data", 64'(wr_data), 0);

        prog_mode = 1'b1; rst_pol = 1'b1; #1;
        chk(cas_oe == 1'b1 && cas_out == 1'b1, "R8 cascade high", 64'({cas_oe, cas_out}), 3);
        rst_pol = 1'b0; #1;
        chk(cas_oe == 1'b1 && cas_out == 1'b0, "R8 cascade low", 64'({cas_oe, cas_out}), 2);
        step(); step();
        chk(data_oe == 1'b1, "R9 drive on mode entry", 64'(data_oe), 1);

        // R11: strobes before any clear are ignored
        sclk_en = 1'b1; sdin = 1'b1; step(); step(); sclk_en = 1'b0;
        chk(wr_data == '0 && wr_addr == '0, "R11 idle strobes ignored", 64'(wr_data), 0);

        // R2: partial load discarded by a clear
        ce_n = 1'b0; step(); ce_n = 1'b1; step();
        for (int i = 0; i < 10; i++) begin sdin = 1'b1; sclk_en = 1'b1; step(); end
        sclk_en = 1'b0;
        chk(wr_data == 32'h3FF, "R3 partial shift", 64'(wr_data), 64'h3FF);

        for (int w = 0; w < NW; w++) begin
            write_word(w, pat(w, 0), (w == 1), w);
            if (w == 0) chk(err_flag == 1'b0, "R5 no error without strobe", 64'(err_flag), 0);
            if (w == 1) begin
                sclk_en = 1'b1; sdin = 1'b1; step(); sclk_en = 1'b0;
                chk(wr_data == pat(1, 0) && wr_addr == AW'(2), "R11 strobes after increment ignored",
                    64'(wr_data), 64'(pat(1, 0)));
            end
        end

        // R7: load after last word
        ce_n = 1'b0; step(); ce_n = 1'b1; step();
        for (int i = 0; i < DW; i++) begin sdin = 1'b1; sclk_en = 1'b1; step(); end
        sclk_en = 1'b0;
        chk(ovf_flag == 1'b1, "R7 overflow flag", 64'(ovf_flag), 1);
        chk(wr_en == 1'b0 && wr_data == '0, "R7 no strobe, no shift", 64'({wr_en, wr_data}), 0);
        chk(wr_addr == AW'(NW - 1), "R6 saturated address", 64'(wr_addr), 64'(NW - 1));

        // R10: exit mode
        prog_mode = 1'b0; #1;
        chk(cas_oe == 1'b0 && cas_out == 1'b0, "R8 cascade released", 64'({cas_oe, cas_out}), 0);
        step();
        chk(wr_addr == '0 && wr_data == '0 && !err_flag && !ovf_flag, "R10 exit clears",
            64'({wr_addr, err_flag, ovf_flag}), 0);
        prog_mode = 1'b1; step();
        write_word(0, pat(7, 3), 1'b0, 0);
        chk(ovf_flag == 1'b0, "R10 new pass without overflow", 64'(ovf_flag), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule